// File: doc/BRIEF.md
# CPU Interrupt Recognition Timing Unit

This block is the interrupt-polling stage of a cycle-stepped 8-bit CPU sequencer. The sequencer describes each instruction to it as an abstract stream of cycles. Each cycle carries a strobe, the index of the cycle within its instruction (index 0 is always the opcode fetch), a flag for the instruction's closing cycle, and, for branches, a taken flag and a page-crossing flag. From this stream and a level-sensitive interrupt line with a mask bit, the block decides when the next opcode-fetch slot is replaced by an interrupt entry sequence. It pulses `entry_start` in that slot.

Polling normally happens in an instruction's closing cycle. A taken branch that stays on its page behaves differently. Its closing cycle behaves like a fetch and does no polling. The branch is polled one cycle earlier instead, in cycle index 1. A request that first shows up in the branch's closing cycle therefore waits through the whole following instruction. In the entry slot the block also reports how many strobed cycles passed from the first cycle where an unmasked request was seen to the entry slot. A testbench can check interrupt latency from this value. Ordinary latency spans 1 to 7 cycles. The branch hold-off adds an eighth value, 8, when the following instruction is 7 cycles long.

The controller is a six-state machine. The states are:
- `ST_BOOT`: the first cycle after reset, which never polls.
- `ST_IDLE`: no request is being tracked.
- `ST_WAIT`: a request is seen and is being timed, but has not yet been polled.
- `ST_LATCHED`: the request was polled early in a branch, and entry waits for the instruction's end.
- `ST_ENTER`: the entry slot.
- `ST_HOLD`: after entry, waiting for the line to go inactive.

Transitions occur only on strobed cycles:
- boot→wait (the line is active) or boot→idle.
- idle→enter (polled in a closing cycle), idle→latched (polled in branch index 1) or idle→wait (active, not polled).
- wait→idle (the request dropped before its poll), wait→enter, wait→latched.
- latched→enter (closing cycle).
- enter→hold (the line is still active) or enter→idle.
- hold→idle (the line is inactive).

Top module: `irq_recog_timer`

## Requirements
- R1: Reset is synchronous and active-high. While it is applied and in the cycle after it, `entry_start` and `lat_valid` are 0 and `lat_cycles` is 0. The first strobed cycle after reset never polls. A request held active from that cycle, followed by a 2-cycle instruction, is entered after that instruction with latency 3.
- R2: In an ordinary instruction of N cycles, a request first seen at index k is entered in the next strobed cycle after the closing cycle, with `lat_cycles` = N−k. This covers 1 to 7 cycles.
- R3: While `irq_mask` is 1 the request line is ignored: there is no entry and no latency report.
- R4: A request that goes inactive before it has been polled is lost, and no entry follows.
- R5: In a taken, non-page-crossing branch (3 cycles), a request first seen in the closing cycle (index 2) is entered only after the following instruction. Its latency is 1 plus that instruction's length: 8 for a 7-cycle instruction, 3 for a 2-cycle instruction.
- R6: In that same branch, a request first seen at index 0 or 1 is entered right after the branch, with latency 3 or 2.
- R7: A taken branch that crosses a page (4 cycles) and a branch that is not taken (2 cycles) poll in their closing cycle. A request first seen there has latency 1, so branches never produce a 9- or 10-cycle latency.
- R8: Once polled, a request is kept even if the line drops before the entry slot.
- R9: `entry_start` and `lat_valid` are asserted together for one strobed cycle per entry. Cycles without a strobe neither advance the block nor show an entry.
- R10: After an entry, a line that stays active does not cause a second entry. A new request counts only after the line has been seen inactive (low or masked) in a strobed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Cycle strobe; the block advances only when high |
| cyc_idx | input | IDX_W | Cycle index within the instruction; 0 is the opcode fetch |
| last_cyc | input | 1 | This is the instruction's closing cycle |
| br_taken | input | 1 | Current instruction is a taken branch |
| pg_cross | input | 1 | The taken branch crosses a page |
| irq_req | input | 1 | Level-sensitive interrupt request, active high |
| irq_mask | input | 1 | When high, the request line is ignored |
| entry_start | output | 1 | This strobed cycle is the interrupt entry slot |
| lat_valid | output | 1 | `lat_cycles` is valid (one-cycle pulse) |
| lat_cycles | output | LAT_W | Cycles from first unmasked request to the entry slot |

## Verification
The main function is tried by sweeping where the request first appears across a 7-cycle instruction, and in shorter ones. Each position gives its own latency, which separates a correct closing-cycle poll from a poll one cycle early or late. Requests placed at each index of a taken same-page branch, followed by instructions of different lengths, separate the hold-off (8 and 3) from a uniform poll (1). Page-crossing and not-taken branches show that the hold-off is confined to the same-page case. Masked, dropped, held-after-poll, stalled and long-held requests separate losing a request, keeping a request, and repeating an entry.

// File: rtl/irt_pkg.sv
package irt_pkg;

    // Controller states of the interrupt recognition unit
    typedef enum logic [2:0] {
        ST_BOOT    = 3'd0,
        ST_IDLE    = 3'd1,
        ST_WAIT    = 3'd2,
        ST_LATCHED = 3'd3,
        ST_ENTER   = 3'd4,
        ST_HOLD    = 3'd5
    } irt_state_e;

endpackage

// File: rtl/irt_poll_gate.sv
// Decides whether the current strobed cycle is a polling point.
module irt_poll_gate #(
    parameter int IDX_W       = 3,
    parameter bit BR_HOLDOFF  = 1'b1,
    parameter int BR_POLL_IDX = 1
) (
    input  logic [IDX_W-1:0] cyc_idx,
    input  logic             last_cyc,
    input  logic             br_taken,
    input  logic             pg_cross,
    output logic             poll
);
    localparam logic [IDX_W-1:0] EARLY_IDX = IDX_W'(BR_POLL_IDX);

    logic fetch_cyc;
    assign fetch_cyc = (cyc_idx == '0);

    generate
        if (BR_HOLDOFF) begin : g_holdoff
            logic same_page_br;
            always_comb begin
                same_page_br = br_taken && !pg_cross;
                if (fetch_cyc)
                    poll = 1'b0;
                else if (same_page_br)
                    poll = (cyc_idx == EARLY_IDX);
                else
                    poll = last_cyc;
            end
        end else begin : g_uniform
            logic unused_br;
            always_comb begin
                unused_br = br_taken ^ pg_cross;
                poll      = last_cyc && !fetch_cyc;
            end
        end
    endgenerate

endmodule

// File: rtl/irt_lat_ctr.sv
// Saturating latency counter: clear, load one, or step.
module irt_lat_ctr #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    output logic [LAT_W-1:0] cnt
);
    localparam logic [LAT_W-1:0] CNT_ONE = LAT_W'(1);
    localparam logic [LAT_W-1:0] CNT_TOP = '1;

    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (en) begin
            if (clr)
                cnt_q <= '0;
            else if (load)
                cnt_q <= CNT_ONE;
            else if (step && (cnt_q != CNT_TOP))
                cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/irq_recog_timer.sv
module irq_recog_timer #(
    parameter int IDX_W       = 3,
    parameter int LAT_W       = 4,
    parameter bit BR_HOLDOFF  = 1'b1,
    parameter int BR_POLL_IDX = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_en,
    input  logic [IDX_W-1:0] cyc_idx,
    input  logic             last_cyc,
    input  logic             br_taken,
    input  logic             pg_cross,
    input  logic             irq_req,
    input  logic             irq_mask,
    output logic             entry_start,
    output logic             lat_valid,
    output logic [LAT_W-1:0] lat_cycles
);
    import irt_pkg::*;

    irt_state_e       state_q, state_d;
    logic             poll;
    logic             req_act;
    logic             ctr_clr, ctr_load, ctr_step;
    logic [LAT_W-1:0] lat_cnt;

    assign req_act = irq_req && !irq_mask;

    irt_poll_gate #(
        .IDX_W      (IDX_W),
        .BR_HOLDOFF (BR_HOLDOFF),
        .BR_POLL_IDX(BR_POLL_IDX)
    ) u_gate (
        .cyc_idx (cyc_idx),
        .last_cyc(last_cyc),
        .br_taken(br_taken),
        .pg_cross(pg_cross),
        .poll    (poll)
    );

    irt_lat_ctr #(
        .LAT_W(LAT_W)
    ) u_ctr (
        .clk (clk),
        .rst (rst),
        .en  (cyc_en),
        .clr (ctr_clr),
        .load(ctr_load),
        .step(ctr_step),
        .cnt (lat_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_BOOT;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cyc_en) begin
            unique case (state_q)
                ST_BOOT:
                    state_d = req_act ? ST_WAIT : ST_IDLE;
                ST_IDLE, ST_WAIT: begin
                    if (!req_act)
                        state_d = ST_IDLE;
                    else if (poll)
                        state_d = last_cyc ? ST_ENTER : ST_LATCHED;
                    else
                        state_d = ST_WAIT;
                end
                ST_LATCHED:
                    state_d = last_cyc ? ST_ENTER : ST_LATCHED;
                ST_ENTER:
                    state_d = req_act ? ST_HOLD : ST_IDLE;
                ST_HOLD:
                    state_d = req_act ? ST_HOLD : ST_IDLE;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    // Output and counter-control logic
    always_comb begin
        entry_start = 1'b0;
        lat_valid   = 1'b0;
        lat_cycles  = '0;
        ctr_clr     = 1'b0;
        ctr_load    = 1'b0;
        ctr_step    = 1'b0;
        unique case (state_q)
            ST_BOOT, ST_IDLE: begin
                ctr_load = req_act;
                ctr_clr  = !req_act;
            end
            ST_WAIT: begin
                ctr_step = req_act;
                ctr_clr  = !req_act;
            end
            ST_LATCHED:
                ctr_step = 1'b1;
            ST_ENTER: begin
                entry_start = cyc_en;
                lat_valid   = cyc_en;
                lat_cycles  = cyc_en ? lat_cnt : '0;
                ctr_clr     = 1'b1;
            end
            ST_HOLD:
                ctr_clr = 1'b1;
            default:
                ctr_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk #(
    parameter int IDX_W       = 3,
    parameter int LAT_W       = 4,
    parameter bit BR_HOLDOFF  = 1'b1,
    parameter int BR_POLL_IDX = 1
) (
    input logic                clk,
    input logic                rst,
    input logic                cyc_en,
    input logic [IDX_W-1:0]    cyc_idx,
    input logic                last_cyc,
    input logic                br_taken,
    input logic                pg_cross,
    input logic                irq_req,
    input logic                irq_mask,
    input logic                entry_start,
    input logic                lat_valid,
    input logic [LAT_W-1:0]    lat_cycles,
    input irt_pkg::irt_state_e state
);
    import irt_pkg::*;

    logic ordinary_close;
    assign ordinary_close = cyc_en && last_cyc && (cyc_idx != '0)
                            && !(BR_HOLDOFF && br_taken && !pg_cross);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!entry_start && !lat_valid && lat_cycles == '0));

    // R2
    ordinary_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (ordinary_close && irq_req && !irq_mask
         && (state == ST_IDLE || state == ST_WAIT)) |=> (state == ST_ENTER));

    // R4
    lost_request_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && cyc_en && !(irq_req && !irq_mask)) |=> (state == ST_IDLE));

    // R8
    latched_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCHED) |=> (state == ST_LATCHED || state == ST_ENTER));

    // R9
    entry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        entry_start |=> !entry_start);

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |-> (!entry_start && !lat_valid));

    // R2
    lat_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lat_valid |-> (lat_cycles != '0));

endmodule

bind irq_recog_timer irq_recog_chk #(
    .IDX_W      (IDX_W),
    .LAT_W      (LAT_W),
    .BR_HOLDOFF (BR_HOLDOFF),
    .BR_POLL_IDX(BR_POLL_IDX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_en     (cyc_en),
    .cyc_idx    (cyc_idx),
    .last_cyc   (last_cyc),
    .br_taken   (br_taken),
    .pg_cross   (pg_cross),
    .irq_req    (irq_req),
    .irq_mask   (irq_mask),
    .entry_start(entry_start),
    .lat_valid  (lat_valid),
    .lat_cycles (lat_cycles),
    .state      (state_q)
);

// File: tb/irq_recog_timer_tb.sv
module irq_recog_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b0;
    logic [2:0] cyc_idx = '0;
    logic       last_cyc = 1'b0;
    logic       br_taken = 1'b0;
    logic       pg_cross = 1'b0;
    logic       irq_req = 1'b0;
    logic       irq_mask = 1'b0;
    logic       entry_start, lat_valid;
    logic [3:0] lat_cycles;

    int n_chk = 0;
    int n_fail = 0;
    int ent_cnt = 0;
    int ent_lat = 0;
    int lv_cnt = 0;
    int stall_bad = 0;
    logic irq_d = 1'b0;

    always #5 clk = ~clk;

    irq_recog_timer u_dut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .cyc_idx(cyc_idx),
        .last_cyc(last_cyc), .br_taken(br_taken), .pg_cross(pg_cross),
        .irq_req(irq_req), .irq_mask(irq_mask), .entry_start(entry_start),
        .lat_valid(lat_valid), .lat_cycles(lat_cycles)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        ent_cnt = 0; ent_lat = 0; lv_cnt = 0; stall_bad = 0;
    endtask

    // One clock: drive after falling edge, sample outputs before rising edge
    task automatic step(bit en, int idx, bit last, bit tk, bit pc, bit msk);
        @(negedge clk);
        cyc_en   = en;
        cyc_idx  = 3'(idx);
        last_cyc = last;
        br_taken = tk;
        pg_cross = pc;
        irq_req  = irq_d;
        irq_mask = msk;
        #1;
        if (entry_start) begin
            ent_cnt++;
            ent_lat = int'(lat_cycles);
        end
        if (lat_valid) lv_cnt++;
        if (!en && (entry_start || lat_valid)) stall_bad++;
    endtask

    // One instruction of n cycles; line rises at index rise, falls at index fall
    task automatic insn(int n, bit tk, bit pc, int rise, int fall, bit msk);
        for (int k = 0; k < n; k++) begin
            if (k == rise) irq_d = 1'b1;
            if (k == fall) irq_d = 1'b0;
            step(1'b1, k, k == n - 1, tk, pc, msk);
        end
    endtask

    task automatic flush();
        irq_d = 1'b0;
        insn(2, 0, 0, -1, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        clr_mon();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step(1'b0, 0, 0, 0, 0, 0);
        chk("R1 entry_start in reset", int'(entry_start), 0);
        chk("R1 lat_valid in reset", int'(lat_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        // first strobed cycle after reset looks like a closing cycle but must not poll
        irq_d = 1'b1;
        step(1'b1, 2, 1, 0, 0, 0);
        chk("R1 no entry right after reset", ent_cnt, 0);
        insn(2, 0, 0, -1, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R1 entries after boot", ent_cnt, 1);
        chk("R1 boot latency", ent_lat, 3);
        flush();
    endtask

    task automatic t_ordinary();
        for (int k = 0; k < 7; k++) begin
            insn(7, 0, 0, k, -1, 0);
            insn(2, 0, 0, -1, -1, 0);
            chk($sformatf("R2 7-cycle entries k=%0d", k), ent_cnt, 1);
            chk($sformatf("R2 7-cycle latency k=%0d", k), ent_lat, 7 - k);
            flush();
        end
        insn(4, 0, 0, 1, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R2 4-cycle latency k=1", ent_lat, 3);
        flush();
        insn(2, 0, 0, 1, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R2 2-cycle latency k=1", ent_lat, 1);
        flush();
    endtask

    task automatic t_mask();
        insn(4, 0, 0, 0, -1, 1);
        insn(3, 0, 0, -1, -1, 1);
        insn(2, 0, 0, -1, 0, 1);
        chk("R3 masked entries", ent_cnt, 0);
        chk("R3 masked latency reports", lv_cnt, 0);
        flush();
    endtask

    task automatic t_drop();
        insn(5, 0, 0, 1, 3, 0);
        insn(3, 0, 0, -1, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R4 dropped request entries", ent_cnt, 0);
        flush();
    endtask

    task automatic t_holdoff();
        insn(3, 1, 0, 2, -1, 0);
        insn(7, 0, 0, -1, -1, 0);
        chk("R5 no entry after branch", ent_cnt, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R5 entries", ent_cnt, 1);
        chk("R5 latency behind 7-cycle", ent_lat, 8);
        flush();
        insn(3, 1, 0, 2, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R5 latency behind 2-cycle", ent_lat, 3);
        flush();
    endtask

    task automatic t_branch_early();
        insn(3, 1, 0, 0, -1, 0);
        insn(7, 0, 0, -1, -1, 0);
        chk("R6 latency at index 0", ent_lat, 3);
        chk("R6 entries at index 0", ent_cnt, 1);
        flush();
        insn(3, 1, 0, 1, -1, 0);
        insn(7, 0, 0, -1, -1, 0);
        chk("R6 latency at index 1", ent_lat, 2);
        flush();
    endtask

    task automatic t_other_branch();
        insn(4, 1, 1, 3, -1, 0);
        insn(7, 0, 0, -1, -1, 0);
        chk("R7 page-cross latency", ent_lat, 1);
        chk("R7 page-cross entries", ent_cnt, 1);
        flush();
        insn(2, 0, 0, 1, -1, 0);
        insn(7, 0, 0, -1, -1, 0);
        chk("R7 not-taken latency", ent_lat, 1);
        flush();
    endtask

    task automatic t_held();
        insn(3, 1, 0, 1, 2, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R8 kept after drop entries", ent_cnt, 1);
        chk("R8 kept after drop latency", ent_lat, 2);
        flush();
    endtask

    task automatic t_stall();
        insn(3, 0, 0, 2, -1, 0);
        repeat (3) step(1'b0, 0, 0, 0, 0, 0);
        chk("R9 no entry during stall", stall_bad + ent_cnt, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R9 latency after stall", ent_lat, 1);
        chk("R9 valid pulse width", lv_cnt, 1);
        flush();
    endtask

    task automatic t_release();
        insn(3, 0, 0, 0, -1, 0);
        insn(3, 0, 0, -1, -1, 0);
        insn(3, 0, 0, -1, -1, 0);
        insn(3, 0, 0, -1, -1, 0);
        chk("R10 single entry while held", ent_cnt, 1);
        insn(3, 0, 0, 0, -1, 1);
        insn(3, 0, 0, -1, -1, 0);
        insn(2, 0, 0, -1, -1, 0);
        chk("R10 re-entry after masked cycle", ent_cnt, 2);
        chk("R10 re-entry latency", ent_lat, 3);
        flush();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_ordinary();
        t_mask();
        t_drop();
        t_holdoff();
        t_branch_early();
        t_other_branch();
        t_held();
        t_stall();
        t_release();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule